// File: doc/BRIEF.md
# Two-Window Antenna Diversity Comparator

This block chooses between two antennas by comparing the strongest signal-strength sample seen in each of two back-to-back measurement periods. An external sequencer raises a window strobe for the whole measurement. It also pulses a control strobe: low for a reset phase, high for the first period, low for a second reset phase, then high for the second period. The antenna itself is switched outside the block between the two periods.

While the window is open the block holds its measurement power-enable high. It zeroes an internal peak tracker during each reset phase and signals this on a clear output. The tracker follows the largest sample seen while the control strobe is high. At the end of the first period the tracker's value is saved. In the second period the tracker is compared against that saved value. When the window closes, the comparison result is stored in a best-antenna flag, which then stays stable until the next window opens.

Top module: `antdiv_cmp`

## Requirements
- R1: The cycle after the clock edge that first samples `win_i` high, `best_o` is 0 and `pwr_en_o` is 1, whatever the flag held before.
- R2: `clr_o` is 1 in the cycle after an edge that zeroes the tracker: the window's rising edge, or any edge in a reset phase (or right after the first period) where `ctl_i` is sampled low. It is 0 in the cycle after an edge where `win_i` and `ctl_i` are both sampled high, other than the rising edge.
- R3: The first-period peak is the largest unsigned 8-bit `sample_i` value sampled at edges where `win_i` and `ctl_i` are both high during the first period.
- R4: The second-period peak is the largest such sample taken during the second period.
- R5: At the first edge that samples `win_i` low after the second period has begun, `best_o` takes the value 1 if the second peak is strictly larger than the first, and 0 otherwise. The new value is visible in the following cycle.
- R6: When the two peaks are equal, `best_o` is 0, so the first antenna is preferred.
- R7: `pwr_en_o` stays 1 for the cycle after the edge that first samples `win_i` low, and is 0 from the cycle after that while `win_i` stays low.
- R8: Outside a window, and within a window except at its rising edge, `best_o` does not change. It changes only at the two edges named in R1 and R5.
- R9: If the window closes before the second period has begun, `best_o` keeps the 0 it was given at the window's rising edge.
- R10: Samples presented while `ctl_i` is low, or while `win_i` is low, have no effect on either peak or on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_i | input | 1 | Measurement window strobe |
| ctl_i | input | 1 | Acquisition control strobe (high = acquire, low = reset phase) |
| sample_i | input | W (8) | Unsigned signal-strength sample |
| best_o | output | 1 | Best-antenna flag: 0 = first period, 1 = second period |
| pwr_en_o | output | 1 | Measurement circuit power-enable |
| clr_o | output | 1 | Peak tracker clear indication |

## Verification
The assertions check the edge-timed control behaviour on every cycle. These are the forced-low flag and raised power at window start, the one-cycle power tail after the window closes, the flag staying stable away from the two decision edges, and the clear output staying silent during acquisition. Only the bench's scenarios can show that the latched flag is the right one. This needs its expected peaks for random and directed sample sets, including equal peaks, extreme values, large samples placed in the reset phases, and a window that is aborted during the first period.

// File: rtl/antdiv_pkg.sv
package antdiv_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CLR_A = 3'd1,
    PH_ACQ_A = 3'd2,
    PH_CLR_B = 3'd3,
    PH_ACQ_B = 3'd4
  } antdiv_phase_e;
endpackage

// File: rtl/antdiv_seq.sv
module antdiv_seq
  import antdiv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic win_i,
  input  logic ctl_i,
  output logic rise_o,
  output logic clear_o,
  output logic take_o,
  output logic hold_o,
  output logic decide_o,
  output logic pwr_en_o
);
  logic          win_q;
  antdiv_phase_e phase, phase_nx;

  assign rise_o   = win_i & ~win_q;
  assign take_o   = win_i & ctl_i & (phase != PH_IDLE);
  assign hold_o   = win_i & ~ctl_i & (phase == PH_ACQ_A);
  assign clear_o  = rise_o |
                    (win_i & ~ctl_i & ((phase == PH_CLR_A) | (phase == PH_ACQ_A) |
                                       (phase == PH_CLR_B)));
  assign decide_o = ~win_i & win_q & (phase == PH_ACQ_B);

  always_comb begin
    phase_nx = phase;
    if (!win_i) begin
      phase_nx = PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE:  phase_nx = PH_CLR_A;
        PH_CLR_A: if (ctl_i)  phase_nx = PH_ACQ_A;
        PH_ACQ_A: if (!ctl_i) phase_nx = PH_CLR_B;
        PH_CLR_B: if (ctl_i)  phase_nx = PH_ACQ_B;
        default:  phase_nx = phase;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q    <= 1'b0;
      phase    <= PH_IDLE;
      pwr_en_o <= 1'b0;
    end else begin
      win_q    <= win_i;
      phase    <= phase_nx;
      pwr_en_o <= win_i | win_q;
    end
  end
endmodule

// File: rtl/antdiv_peak.sv
module antdiv_peak #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear_i,
  input  logic         take_i,
  input  logic [W-1:0] sample_i,
  output logic [W-1:0] peak_o
);
  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      peak_o <= '0;
    end else if (take_i && (sample_i > peak_o)) begin
      peak_o <= sample_i;
    end
  end
endmodule

// File: rtl/antdiv_decide.sv
module antdiv_decide #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rise_i,
  input  logic         hold_i,
  input  logic         decide_i,
  input  logic [W-1:0] trk_i,
  output logic         best_o
);
  logic [W-1:0] held_a;
  logic         b_wins;

  assign b_wins = trk_i > held_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_a <= '0;
      best_o <= 1'b0;
    end else begin
      if (rise_i)      held_a <= '0;
      else if (hold_i) held_a <= trk_i;
      if (rise_i)        best_o <= 1'b0;
      else if (decide_i) best_o <= b_wins;
    end
  end
endmodule

// File: rtl/antdiv_cmp.sv
module antdiv_cmp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         win_i,
  input  logic         ctl_i,
  input  logic [W-1:0] sample_i,
  output logic         best_o,
  output logic         pwr_en_o,
  output logic         clr_o
);
  logic         rise, clear, take, hold, decide;
  logic [W-1:0] trk;

  antdiv_seq seq_i (
    .clk(clk), .rst(rst), .win_i(win_i), .ctl_i(ctl_i),
    .rise_o(rise), .clear_o(clear), .take_o(take), .hold_o(hold),
    .decide_o(decide), .pwr_en_o(pwr_en_o)
  );

  antdiv_peak #(.W(W)) peak_i (
    .clk(clk), .rst(rst), .clear_i(clear), .take_i(take),
    .sample_i(sample_i), .peak_o(trk)
  );

  antdiv_decide #(.W(W)) dec_i (
    .clk(clk), .rst(rst), .rise_i(rise), .hold_i(hold),
    .decide_i(decide), .trk_i(trk), .best_o(best_o)
  );

  always_ff @(posedge clk) begin
    if (rst) clr_o <= 1'b0;
    else     clr_o <= clear;
  end
endmodule

// File: rtl/antdiv_cmp_chk.sv
module antdiv_cmp_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         win_i,
  input logic         ctl_i,
  input logic [W-1:0] sample_i,
  input logic         best_o,
  input logic         pwr_en_o,
  input logic         clr_o
);
  assert_rise_flag_low_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(win_i) |=> (!best_o && pwr_en_o));

  assert_no_clear_in_acq_R2: assert property (@(posedge clk) disable iff (rst)
    (win_i && ctl_i && !$rose(win_i)) |=> !clr_o);

  assert_pwr_tail_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(win_i) |=> pwr_en_o);

  assert_pwr_off_R7: assert property (@(posedge clk) disable iff (rst)
    (!win_i && !$fell(win_i)) |=> !pwr_en_o);

  assert_flag_steady_R8: assert property (@(posedge clk) disable iff (rst)
    (!$rose(win_i) && !$fell(win_i)) |=> $stable(best_o));

  logic unused_ok;
  assign unused_ok = ^sample_i;
endmodule

bind antdiv_cmp antdiv_cmp_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .win_i(win_i), .ctl_i(ctl_i), .sample_i(sample_i),
  .best_o(best_o), .pwr_en_o(pwr_en_o), .clr_o(clr_o)
);

// File: tb/antdiv_cmp_tb_top.sv
`timescale 1ns/1ps
module antdiv_cmp_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         win_i = 1'b0;
  logic         ctl_i = 1'b0;
  logic [W-1:0] sample_i = '0;
  logic         best_o, pwr_en_o, clr_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [W-1:0] sa [8];
  logic [W-1:0] sb [8];

  always #2 clk = ~clk;

  antdiv_cmp #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .win_i(win_i), .ctl_i(ctl_i), .sample_i(sample_i),
    .best_o(best_o), .pwr_en_o(pwr_en_o), .clr_o(clr_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] peak_of(input bit second);
    logic [W-1:0] m = '0;
    for (int i = 0; i < 8; i++) begin
      if (second) begin if (sb[i] > m) m = sb[i]; end
      else        begin if (sa[i] > m) m = sa[i]; end
    end
    return m;
  endfunction

  // full window; large noise in reset phases must be ignored (R10)
  task automatic run_window(input string tag);
    logic exp_best;
    exp_best = peak_of(1'b1) > peak_of(1'b0);
    @(negedge clk); win_i = 1'b1; ctl_i = 1'b0; sample_i = W'($urandom);
    @(negedge clk);
    chk({tag, " R1 flag"}, best_o, 0);
    chk({tag, " R1 pwr"}, pwr_en_o, 1);
    chk({tag, " R2 clr rise"}, clr_o, 1);
    for (int i = 0; i < 3; i++) begin sample_i = W'($urandom) | 8'h80; @(negedge clk); end
    chk({tag, " R2 clr phase"}, clr_o, 1);
    for (int i = 0; i < 8; i++) begin
      ctl_i = 1'b1; sample_i = sa[i]; @(negedge clk);
      if (i == 1) chk({tag, " R2 clr acq"}, clr_o, 0);
    end
    for (int i = 0; i < 4; i++) begin ctl_i = 1'b0; sample_i = 8'hFF; @(negedge clk); end
    for (int i = 0; i < 8; i++) begin
      ctl_i = 1'b1; sample_i = sb[i]; @(negedge clk);
      if (i == 3) chk({tag, " R8 flag in window"}, best_o, 0);
    end
    win_i = 1'b0; sample_i = 8'hFF;
    @(negedge clk);
    chk({tag, " R5/R3/R4 decision"}, best_o, exp_best);
    chk({tag, " R7 pwr tail"}, pwr_en_o, 1);
    ctl_i = 1'b0;
    @(negedge clk);
    chk({tag, " R7 pwr off"}, pwr_en_o, 0);
    for (int i = 0; i < 5; i++) begin
      ctl_i = 1'($urandom); sample_i = W'($urandom); @(negedge clk);
    end
    ctl_i = 1'b0;
    chk({tag, " R8 flag held"}, best_o, exp_best);
  endtask

  initial begin
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("reset best", best_o, 0);
    chk("reset pwr", pwr_en_o, 0);
    chk("reset clr", clr_o, 0);
    rst = 1'b0;

    // directed: second clearly larger
    for (int i = 0; i < 8; i++) begin sa[i] = 8'd10 + 8'(i); sb[i] = 8'd200; end
    run_window("dir_b_wins");
    // directed: first larger, flag goes back to 0 (R1 forces low first)
    for (int i = 0; i < 8; i++) begin sa[i] = 8'd0; sb[i] = 8'd5; end
    sa[7] = 8'd255;
    run_window("dir_a_wins");
    // R6 equal peaks
    for (int i = 0; i < 8; i++) begin sa[i] = 8'(i * 3); sb[i] = 8'(21 - i * 3); end
    run_window("R6 equal");
    // equal at zero
    for (int i = 0; i < 8; i++) begin sa[i] = 8'd0; sb[i] = 8'd0; end
    run_window("R6 zeros");
    // last sample of period B decides, max value
    for (int i = 0; i < 8; i++) begin sa[i] = 8'd254; sb[i] = 8'd1; end
    sb[7] = 8'd255;
    run_window("R4 last sample");

    // R9 aborted window after a window that set the flag
    for (int i = 0; i < 8; i++) begin sa[i] = 8'd1; sb[i] = 8'd9; end
    run_window("pre_abort");
    @(negedge clk); win_i = 1'b1; ctl_i = 1'b0; sample_i = 8'd3;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3; i++) begin ctl_i = 1'b1; sample_i = 8'd100; @(negedge clk); end
    win_i = 1'b0;
    @(negedge clk);
    chk("R9 abort flag", best_o, 0);
    ctl_i = 1'b0;
    @(negedge clk);
    chk("R9 abort pwr", pwr_en_o, 0);

    // random windows
    for (int n = 0; n < 20; n++) begin
      for (int i = 0; i < 8; i++) begin
        sa[i] = W'($urandom); sb[i] = W'($urandom);
        if (n[0]) sb[i] = sb[i] >> 1;
      end
      run_window("R5 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule